// File: doc/BRIEF.md
# Selectable-Interval GPIO Input Debouncer

This block filters a small group of general-purpose input pins so that contact bounce and short glitches never reach the rest of the chip. Each pin is synchronized and then drives its own stability counter. The counter advances on a 1 ms enable pulse, which a free-running prescaler derives from the system clock. A pin's filtered level changes only after the raw level has stayed at a new value for the whole selected interval. Any toggle before that starts the count again.

A configuration write loads a 2-bit interval code and a host-override flag. The interval codes do not increase in order: 00 = 20 ms, 01 = 40 ms, 10 = 10 ms and 11 = 5 ms. The filtered levels land in a pin-setting register. While the override flag is set, that register disconnects from the pins and takes its value only from a host write strobe with data. When the flag is cleared again, each bit of the register follows its pin again from that pin's next settled transition.

Top module: `gpio_debounce_top`

## Requirements
- R1: After reset, `pinReg` is all zeros, all stability counters are cleared, the interval code is 00 and the override flag is 0.
- R2: Let D = CLK_FREQ_HZ/1000 clock cycles, which is one 1 ms tick. With code 00, a level change on a pin that is then held appears in `pinReg` no earlier than 20·D cycles and no later than 21·D+5 cycles after the change. `pinReg` changes only in the cycle after a tick.
- R3: Code 01 gives a 40 ms interval, code 10 gives 10 ms and code 11 gives 5 ms. The same window as in R2 applies, with N ms in place of 20.
- R4: If a pin toggles before its interval has elapsed, that pin's counter restarts, so a pulse shorter than the interval never changes `pinReg`.
- R5: A configuration write that changes the interval code clears every counter in progress. Each count then starts again from zero against the new interval.
- R6: While the override flag is set, `hostWrEn` loads `hostWrData` into `pinReg` on the next clock. Pin transitions that settle during override leave `pinReg` unchanged.
- R7: While the override flag is clear, `hostWrEn` has no effect on `pinReg`.
- R8: After the override flag is cleared, `pinReg` keeps the value the host wrote. Each bit updates only when its own pin next completes a settled transition.
- R9: Pins are filtered independently. Each pin's settle time depends only on that pin's own input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_PINS | Raw, unsynchronized pin levels |
| cfgWrEn | input | 1 | Strobe that loads the interval code and the override flag |
| cfgSelIn | input | 2 | Interval code (00=20 ms, 01=40 ms, 10=10 ms, 11=5 ms) |
| cfgOvrIn | input | 1 | Override flag: 1 hands the pin-setting register to the host |
| hostWrEn | input | 1 | Host write strobe for the pin-setting register |
| hostWrData | input | NUM_PINS | Host write data |
| pinReg | output | NUM_PINS | Pin-setting register |

## Verification
A settle result is due between N·D and (N+1)·D cycles after the synchronized level becomes steady. The position inside that window depends on the phase of the free-running tick, and the synchronizer and the compare stage add a few more cycles. Each settle test therefore samples twice. The first sample, at N·D−1 cycles, must still show the old level. The second, at (N+1)·D+5 cycles, must show the new one. The R5 test is timed so that the window of the old interval and the window of the new interval do not overlap. A host write is due in the cycle after its strobe and is checked at the next falling edge. Every "ignored" case is checked again after enough time has passed for a wrongly accepted update to have appeared.

// File: rtl/gpio_db_pkg.sv
package gpio_db_pkg;

  localparam int CNT_W = 6;

  typedef struct packed {
    logic tick;
    logic restart;
  } dbStrobe_t;

  function automatic logic [CNT_W-1:0] selToMs(input logic [1:0] code);
    logic [CNT_W-1:0] ms;
    case (code)
      2'b00:   ms = CNT_W'(20);
      2'b01:   ms = CNT_W'(40);
      2'b10:   ms = CNT_W'(10);
      default: ms = CNT_W'(5);
    endcase
    return ms;
  endfunction

endpackage

// File: rtl/gpio_db_ctrl.sv
module gpio_db_ctrl
  import gpio_db_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 1_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgSelIn,
  input  logic             cfgOvrIn,
  output dbStrobe_t        strobe,
  output logic [CNT_W-1:0] limitMs,
  output logic             ovr
);

  localparam int TICK_DIV = CLK_FREQ_HZ / 1000;
  localparam int PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic [1:0]       selQ;
  logic             ovrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= 2'b00;
      ovrQ <= 1'b0;
    end else if (cfgWrEn) begin
      selQ <= cfgSelIn;
      ovrQ <= cfgOvrIn;
    end
  end

  always_comb begin
    strobe.tick    = (preCnt == PRE_LAST);
    strobe.restart = cfgWrEn && (cfgSelIn != selQ);
  end

  assign limitMs = selToMs(selQ);
  assign ovr     = ovrQ;

endmodule

// File: rtl/gpio_db_path.sv
module gpio_db_path
  import gpio_db_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  dbStrobe_t           strobe,
  input  logic [CNT_W-1:0]    limitMs,
  input  logic                ovr,
  input  logic                hostWrEn,
  input  logic [NUM_PINS-1:0] hostWrData,
  output logic [NUM_PINS-1:0] pinReg
);

  logic [NUM_PINS-1:0] sampleVec;
  logic [NUM_PINS-1:0] settleVec;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   dbQ;
    logic [CNT_W-1:0]       cntQ;
    logic                   sample;
    logic                   steady;
    logic                   differs;

    assign sample  = syncQ[SYNC_STAGES-1];
    assign steady  = (sample == prevQ);
    assign differs = (sample != dbQ);

    assign sampleVec[g] = sample;
    assign settleVec[g] = strobe.tick && !strobe.restart && steady &&
                          differs && (cntQ == limitMs);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn[g]};
        prevQ <= sample;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
        dbQ  <= 1'b0;
      end else if (strobe.restart || !steady || !differs) begin
        cntQ <= '0;
      end else if (strobe.tick) begin
        if (cntQ == limitMs) begin
          cntQ <= '0;
          dbQ  <= sample;
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinReg <= '0;
    end else if (ovr) begin
      if (hostWrEn) begin
        pinReg <= hostWrData;
      end
    end else begin
      pinReg <= (pinReg & ~settleVec) | (sampleVec & settleVec);
    end
  end

endmodule

// File: rtl/gpio_debounce_top.sv
module gpio_debounce_top
  import gpio_db_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int CLK_FREQ_HZ = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSelIn,
  input  logic                cfgOvrIn,
  input  logic                hostWrEn,
  input  logic [NUM_PINS-1:0] hostWrData,
  output logic [NUM_PINS-1:0] pinReg
);

  dbStrobe_t        ctrlS;
  logic [CNT_W-1:0] limitW;
  logic             ovrW;
  logic             tickW;

  assign tickW = ctrlS.tick;

  gpio_db_ctrl #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSelIn(cfgSelIn),
    .cfgOvrIn(cfgOvrIn),
    .strobe  (ctrlS),
    .limitMs (limitW),
    .ovr     (ovrW)
  );

  gpio_db_path #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (ctrlS),
    .limitMs   (limitW),
    .ovr       (ovrW),
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .pinReg    (pinReg)
  );

endmodule

// File: rtl/gpio_debounce_chk.sv
module gpio_debounce_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinReg,
  input logic                hostWrEn,
  input logic [NUM_PINS-1:0] hostWrData,
  input logic                ovr,
  input logic                tick
);

  AST_RST_STATE: assert property (@(posedge clk)
    !rstN |=> (pinReg == '0)); // R1

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R2

  AST_SETTLE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!ovr && !tick) |=> $stable(pinReg)); // R2

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && !hostWrEn) |=> $stable(pinReg)); // R6

  AST_OVR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && hostWrEn) |=> (pinReg == $past(hostWrData))); // R6

endmodule

bind gpio_debounce_top gpio_debounce_chk #(
  .NUM_PINS(NUM_PINS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .pinReg    (pinReg),
  .hostWrEn  (hostWrEn),
  .hostWrData(hostWrData),
  .ovr       (ovrW),
  .tick      (tickW)
);

// File: tb/gpio_debounce_top_tb_top.sv
`timescale 1ns/1ps
module gpio_debounce_top_tb_top;

  localparam int NP = 4;
  localparam int FHZ = 10_000;
  localparam int D = FHZ / 1000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgSelIn = 2'b00;
  logic          cfgOvrIn = 1'b0;
  logic          hostWrEn = 1'b0;
  logic [NP-1:0] hostWrData = '0;
  logic [NP-1:0] pinReg;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  gpio_debounce_top #(
    .NUM_PINS(NP), .CLK_FREQ_HZ(FHZ), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cfgWrEn(cfgWrEn),
    .cfgSelIn(cfgSelIn), .cfgOvrIn(cfgOvrIn), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .pinReg(pinReg)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NP-1:0] exp);
    vectors++;
    if (pinReg !== exp) begin
      miscompares++;
      $display("FAIL %s: pinReg=%b expected=%b at %0t", tag, pinReg, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = '0; cfgWrEn = 1'b0; cfgSelIn = 2'b00;
    cfgOvrIn = 1'b0; hostWrEn = 1'b0; hostWrData = '0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic ovr);
    cfgWrEn = 1'b1; cfgSelIn = sel; cfgOvrIn = ovr;
    waitCyc(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [NP-1:0] data);
    hostWrEn = 1'b1; hostWrData = data;
    waitCyc(1);
    hostWrEn = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 reset value", '0);
  endtask

  // Rise and fall of pin 1 under one interval code.
  task automatic testSel(input logic [1:0] code, input int n, input bit doWrite, input string tag);
    doReset();
    if (doWrite) cfgWrite(code, 1'b0);
    pinIn = 4'b0010;
    waitCyc(n * D - 1);
    chk({tag, " rise not early"}, 4'b0000);
    waitCyc(D + 6);
    chk({tag, " rise settled"}, 4'b0010);
    pinIn = 4'b0000;
    waitCyc(n * D - 1);
    chk({tag, " fall not early"}, 4'b0010);
    waitCyc(D + 6);
    chk({tag, " fall settled"}, 4'b0000);
  endtask

  task automatic testGlitch();
    doReset();
    cfgWrite(2'b11, 1'b0);
    pinIn = 4'b0001; waitCyc(3 * D);
    chk("R4 short pulse 1", 4'b0000);
    pinIn = 4'b0000; waitCyc(D);
    pinIn = 4'b0001; waitCyc(3 * D);
    chk("R4 short pulse 2", 4'b0000);
    pinIn = 4'b0000; waitCyc(D);
    pinIn = 4'b0001; waitCyc(4 * D);
    chk("R4 short pulse 3", 4'b0000);
    pinIn = 4'b0000; waitCyc(10 * D);
    chk("R4 glitches filtered", 4'b0000);
  endtask

  task automatic testIndep();
    doReset();
    cfgWrite(2'b10, 1'b0);
    pinIn = 4'b0001; waitCyc(30);
    pinIn = 4'b0101; waitCyc(90);
    chk("R9 pin0 settled, pin2 pending", 4'b0001);
    waitCyc(30);
    chk("R9 both settled", 4'b0101);
  endtask

  task automatic testRestart();
    doReset();
    pinIn = 4'b1000;
    waitCyc(15 * D);
    cfgWrite(2'b10, 1'b0);
    waitCyc(9 * D - 1);
    chk("R5 count restarted on code change", 4'b0000);
    waitCyc(3 * D);
    chk("R5 settled against new interval", 4'b1000);
  endtask

  task automatic testOverride();
    doReset();
    cfgWrite(2'b11, 1'b1);
    hostWrite(4'b1010);
    chk("R6 host write loaded", 4'b1010);
    pinIn = 4'b0001;
    waitCyc(10 * D);
    chk("R6 settled pin ignored", 4'b1010);
    hostWrite(4'b0101);
    chk("R6 second host write", 4'b0101);
    cfgWrite(2'b11, 1'b0);
    pinIn = 4'b1001;
    waitCyc(4 * D);
    chk("R8 holds host value", 4'b0101);
    waitCyc(3 * D);
    chk("R8 pin3 settles after override off", 4'b1101);
  endtask

  task automatic testIgnore();
    doReset();
    hostWrite(4'b1111);
    waitCyc(1);
    chk("R7 host write ignored", 4'b0000);
    waitCyc(25 * D);
    chk("R7 still ignored later", 4'b0000);
  endtask

  initial begin
    testReset();
    testSel(2'b00, 20, 1'b0, "R2 code00 default");
    testSel(2'b01, 40, 1'b1, "R3 code01");
    testSel(2'b10, 10, 1'b1, "R3 code10");
    testSel(2'b11, 5,  1'b1, "R3 code11");
    testGlitch();
    testIndep();
    testRestart();
    testOverride();
    testIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule